// File: doc/BRIEF.md
# Program Counter Sequencer with Call Link

This block holds the program counter of a single-cycle, word-addressed core with separate instruction and data memories, and it chooses the address fetched next. Each cycle it takes a transfer class from the decoder, the outcome of the branch comparison, one immediate that the decoder has already sign-extended to the address width, and the first source register value. From these it forms the next address. The program counter register loads that address on every rising edge of the clock.

For subroutine calls the block also produces the return address. The return address is the word that follows the current instruction. With it the block produces a write request that names the destination register. A direct call always writes the link register, index 7. A register-indirect call writes the destination field of the instruction. When that field names register 0, the request is suppressed, because register 0 is hardwired to zero.

Each cycle the transfer class selects one of five named paths: sequential step, conditional branch, direct jump, direct call and register-indirect call. No other state exists beyond the program counter itself. The core's instruction memory, register storage and comparison logic sit outside this block.

Top module: `pc_seq_unit`

## Requirements
- R1: With `rst` high at a rising clock edge, `pc_o` becomes 16'h0000 after that edge.
- R2: Class code 0 (sequential) and the unused codes 5, 6 and 7 give `npc_o` = `pc_o` + 1.
- R3: Class code 1 (branch) gives `npc_o` = `pc_o` + `imm_i` when `br_taken_i` is 1, and `pc_o` + 1 when it is 0.
- R4: Class code 2 (jump) gives `npc_o` = `pc_o` + `imm_i` and leaves `link_we_o` at 0.
- R5: Class code 3 (direct call) gives `npc_o` = `pc_o` + `imm_i`, `link_we_o` = 1 and `link_rd_o` = 7.
- R6: Class code 4 (register-indirect call) gives `npc_o` = `rs1_i` + `imm_i`, `link_rd_o` = `rd_i`, and `link_we_o` = 1 unless `rd_i` is 0, in which case `link_we_o` = 0.
- R7: All address sums wrap modulo 2^16. For example, 16'hFFFF + 1 gives 16'h0000.
- R8: With `rst` low at a rising edge, `pc_o` takes the value `npc_o` had just before that edge, so the address advances once per cycle.
- R9: `link_o` always equals `pc_o` + 1, and `link_we_o` is 0 for class codes 0, 1, 2, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the program counter loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 3 | Transfer class: 0 sequential, 1 branch, 2 jump, 3 direct call, 4 register-indirect call, 5 to 7 treated as sequential |
| br_taken_i | input | 1 | Branch comparison outcome; used only for class 1 |
| imm_i | input | 16 | Sign-extended immediate of the current instruction |
| rs1_i | input | 16 | First source register value; the base address for class 4 |
| rd_i | input | 3 | Destination register field of the current instruction |
| pc_o | output | 16 | Current instruction address |
| npc_o | output | 16 | Address the program counter loads at the next edge |
| link_o | output | 16 | Return address (current address plus one) |
| link_we_o | output | 1 | Request to write `link_o` to the register file |
| link_rd_o | output | 3 | Register index for the link write |

## Verification
The clocked assertions assume that `cls_i`, `br_taken_i`, `imm_i`, `rs1_i` and `rd_i` hold known values at every rising edge where `rst` is low. They also assume that these inputs stay steady over the cycle they describe, since the block's outputs are pure functions of them and the program counter. The stimulus meets both assumptions. It holds reset for the first cycles and drives every input to a defined value just after the falling edge, and it leaves each value unchanged until the next falling edge. Directed steps cover wrap-around at both the top and the bottom of the address space, an indirect call with destination 0, the unused class codes and a reset in the middle of a run. Random steps cover the rest of the input space.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int ADDR_W  = 16;
    localparam int RIDX_W  = 3;
    localparam int CLS_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_SEQ    = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_JUMP   = 3'd2,
        CLS_JAL    = 3'd3,
        CLS_JALR   = 3'd4
    } xfer_cls_e;

endpackage

// File: rtl/pcu_addr_gen.sv
// Three parallel address adders: sequential step, PC-relative, register-based.
module pcu_addr_gen #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] imm_i,
    input  logic [AW-1:0] base_i,
    output logic [AW-1:0] seq_addr_o,
    output logic [AW-1:0] rel_addr_o,
    output logic [AW-1:0] reg_addr_o
);
    localparam logic [AW-1:0] STEP = AW'(1);

    // Sums are truncated to AW bits, which gives modulo 2^AW wrap.
    always_comb begin
        seq_addr_o = pc_i + STEP;
        rel_addr_o = pc_i + imm_i;
        reg_addr_o = base_i + imm_i;
    end
endmodule

// File: rtl/pcu_target_sel.sv
// Chooses the next fetch address from the class and branch outcome.
module pcu_target_sel
    import pcu_pkg::*;
#(
    parameter int AW = 16
) (
    input  xfer_cls_e     cls_i,
    input  logic          taken_i,
    input  logic [AW-1:0] seq_addr_i,
    input  logic [AW-1:0] rel_addr_i,
    input  logic [AW-1:0] reg_addr_i,
    output logic [AW-1:0] npc_o
);
    always_comb begin
        unique case (cls_i)
            CLS_SEQ:    npc_o = seq_addr_i;
            CLS_BRANCH: npc_o = taken_i ? rel_addr_i : seq_addr_i;
            CLS_JUMP:   npc_o = rel_addr_i;
            CLS_JAL:    npc_o = rel_addr_i;
            CLS_JALR:   npc_o = reg_addr_i;
            default:    npc_o = seq_addr_i;
        endcase
    end
endmodule

// File: rtl/pcu_link_route.sv
// Produces the register-file write request for the return address.
module pcu_link_route
    import pcu_pkg::*;
#(
    parameter int RW       = 3,
    parameter int LINK_IDX = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_cls_e     cls_i,
    input  logic [RW-1:0] rd_i,
    output logic          we_o,
    output logic [RW-1:0] rd_o
);
    localparam logic [RW-1:0] LINK_REG = RW'(LINK_IDX);
    localparam logic [RW-1:0] ZERO_REG = '0;

    always_comb begin
        unique case (cls_i)
            CLS_JAL: begin
                we_o = 1'b1;
                rd_o = LINK_REG;
            end
            CLS_JALR: begin
                // A write to the hardwired-zero register would be lost; drop it.
                we_o = (rd_i != ZERO_REG);
                rd_o = rd_i;
            end
            default: begin
                we_o = 1'b0;
                rd_o = rd_i;
            end
        endcase
    end

    // R6
    r0_discard_chk: assert property (@(posedge clk) disable iff (rst)
        we_o |-> (rd_o != ZERO_REG));
endmodule

// File: rtl/pcu_pc_reg.sv
// Program counter register with synchronous reset.
module pcu_pc_reg #(
    parameter int          AW       = 16,
    parameter logic [15:0] RST_ADDR = 16'h0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] d_i,
    output logic [AW-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= AW'(RST_ADDR);
        else     q_o <= d_i;
    end
endmodule

// File: rtl/pc_seq_unit.sv
// Next-address and link top level.
module pc_seq_unit
    import pcu_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int RW       = RIDX_W,
    parameter int LINK_IDX = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    cls_i,
    input  logic          br_taken_i,
    input  logic [AW-1:0] imm_i,
    input  logic [AW-1:0] rs1_i,
    input  logic [RW-1:0] rd_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] npc_o,
    output logic [AW-1:0] link_o,
    output logic          link_we_o,
    output logic [RW-1:0] link_rd_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    xfer_cls_e     cls;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] rel_addr;
    logic [AW-1:0] reg_addr;
    logic [AW-1:0] npc;

    assign cls = xfer_cls_e'(cls_i);

    pcu_addr_gen #(.AW(AW)) u_addr (
        .pc_i       (pc_q),
        .imm_i      (imm_i),
        .base_i     (rs1_i),
        .seq_addr_o (seq_addr),
        .rel_addr_o (rel_addr),
        .reg_addr_o (reg_addr)
    );

    pcu_target_sel #(.AW(AW)) u_sel (
        .cls_i      (cls),
        .taken_i    (br_taken_i),
        .seq_addr_i (seq_addr),
        .rel_addr_i (rel_addr),
        .reg_addr_i (reg_addr),
        .npc_o      (npc)
    );

    pcu_link_route #(.RW(RW), .LINK_IDX(LINK_IDX)) u_link (
        .clk   (clk),
        .rst   (rst),
        .cls_i (cls),
        .rd_i  (rd_i),
        .we_o  (link_we_o),
        .rd_o  (link_rd_o)
    );

    pcu_pc_reg #(.AW(AW)) u_pc (
        .clk (clk),
        .rst (rst),
        .d_i (npc),
        .q_o (pc_q)
    );

    assign pc_o   = pc_q;
    assign npc_o  = npc;
    assign link_o = seq_addr;

    // R8
    pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc_q == $past(npc)));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 3'd0) |=> (pc_q == AW'($past(pc_q) + ONE)));

    // R3
    not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 3'd1 && !br_taken_i) |=> (pc_q == AW'($past(pc_q) + ONE)));

    // R5
    jal_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 3'd3) |-> (link_we_o && link_rd_o == RW'(LINK_IDX)));

    // R9
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        link_o == AW'(pc_q + ONE));
endmodule

// File: tb/pc_seq_unit_bench.sv
module pc_seq_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cls;
    logic        taken;
    logic [15:0] imm, rs1;
    logic [2:0]  rd;
    logic [15:0] pc_o, npc_o, link_o;
    logic        link_we_o;
    logic [2:0]  link_rd_o;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] ref_pc = 16'h0;
    bit          prev_rst = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_seq_unit u_pc_seq_unit (
        .clk (clk), .rst (rst), .cls_i (cls), .br_taken_i (taken),
        .imm_i (imm), .rs1_i (rs1), .rd_i (rd),
        .pc_o (pc_o), .npc_o (npc_o), .link_o (link_o),
        .link_we_o (link_we_o), .link_rd_o (link_rd_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, compare, then advance the model.
    task automatic step(input logic r, input logic [2:0] c, input logic t,
                        input logic [15:0] im, input logic [15:0] rs,
                        input logic [2:0] d, input string npc_tag);
        logic [15:0] exp_npc;
        logic [15:0] nxt;
        logic        exp_we;
        string       tag;
        @(negedge clk);
        rst = r; cls = c; taken = t; imm = im; rs1 = rs; rd = d;
        #1;
        nxt = ref_pc + 16'd1;
        case (c)
            3'd1:       exp_npc = t ? 16'(ref_pc + im) : nxt;
            3'd2, 3'd3: exp_npc = 16'(ref_pc + im);
            3'd4:       exp_npc = 16'(rs + im);
            default:    exp_npc = nxt;
        endcase
        exp_we = (c == 3'd3) || (c == 3'd4 && d != 3'd0);
        chk(prev_rst ? "R1" : "R8", "pc", pc_o, ref_pc);
        if (!r) begin
            if (npc_tag != "") tag = npc_tag;
            else case (c)
                3'd1: tag = "R3";
                3'd2: tag = "R4";
                3'd3: tag = "R5";
                3'd4: tag = "R6";
                default: tag = "R2";
            endcase
            chk(tag, "npc", npc_o, exp_npc);
            chk("R9", "link", link_o, nxt);
            chk(c == 3'd4 ? "R6" : (c == 3'd3 ? "R5" : "R9"), "link_we",
                {15'd0, link_we_o}, {15'd0, exp_we});
            if (exp_we) chk(c == 3'd3 ? "R5" : "R6", "link_rd",
                            {13'd0, link_rd_o}, {13'd0, (c == 3'd3) ? 3'd7 : d});
        end
        ref_pc   = r ? 16'h0 : exp_npc;
        prev_rst = r;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cls = 3'd0; taken = 1'b0; imm = 16'h0; rs1 = 16'h0; rd = 3'd0;
        step(1, 0, 0, 0, 0, 0, "");
        step(1, 0, 0, 0, 0, 0, "");
        // R2 sequential and unused codes
        step(0, 0, 0, 16'h0040, 0, 0, "");
        step(0, 5, 1, 16'h0040, 0, 3, "R2");
        step(0, 6, 1, 16'h0040, 0, 3, "R2");
        step(0, 7, 1, 16'h0040, 0, 3, "R2");
        // R3 branch both ways, backward taken
        step(0, 1, 1, 16'h0010, 0, 0, "");
        step(0, 1, 0, 16'h0010, 0, 0, "");
        step(0, 1, 1, 16'hFFFC, 0, 0, "");
        // R4 jump, R5 call
        step(0, 2, 0, 16'h0100, 0, 5, "");
        step(0, 3, 0, 16'hFF00, 0, 2, "");
        // R6 indirect call, with and without r0
        step(0, 4, 0, 16'h0003, 16'h1234, 4, "");
        step(0, 4, 0, 16'hFFFF, 16'h2000, 0, "");
        // R7 wrap: reach 0xFFFF, step to 0, jump below 0, indirect wrap
        step(1, 0, 0, 0, 0, 0, "");
        step(0, 2, 0, 16'hFFFF, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, "R7");
        step(0, 1, 1, 16'hFFFE, 0, 0, "R7");
        step(0, 4, 0, 16'h0020, 16'hFFF0, 1, "R7");
        // R1 reset mid-run
        step(1, 3, 1, 16'h0500, 16'h0, 6, "");
        step(0, 0, 0, 0, 0, 0, "");
        for (int i = 0; i < 400; i++) begin
            logic [2:0] rc;
            rc = 3'($urandom_range(0, 7));
            step(($urandom_range(0, 63) == 0), rc, 1'($urandom),
                 16'($urandom), 16'($urandom), 3'($urandom), "");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule